// File: doc/BRIEF.md
# PLL Ratio Control and Lock Timer

This block is the digital controller that sits beside an analog clock-multiplier PLL. Software writes a ratio word holding a reference divider, a multiplier and a settling count, plus a separate control word holding an output halving select and an interrupt enable. The block stores these values and turns the PLL on only when both the divider and the multiplier are non-zero. With those values the synthesized frequency is the reference times (multiplier + 1) / divider.

Each write of the ratio word that leaves the PLL enabled drops the lock indication and loads the settling count into a down-counter. A slow-clock tick, given as a one-cycle enable on the system clock, steps that counter. When the counter has run out, lock is raised, and the interrupt request follows lock while the interrupt enable is set. The stored divider, multiplier and halving select are brought out so that a behavioural PLL model can use them.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After a synchronous reset, the outputs `div_o`, `mul_o`, `pll_en_o`, `lock_o`, `irq_o` and `half_o` are all 0.
- R2: A write with `wr_addr` = 0 loads the ratio word. The divider is in bits [7:0], the multiplier is in bits [15:8] and the settling count is in bits [21:16]. `div_o` and `mul_o` show the new values in the cycle after the write.
- R3: `pll_en_o` is 1 exactly when the stored divider and the stored multiplier are both non-zero. It is updated in the cycle after a ratio write.
- R4: A ratio write that leaves the PLL enabled clears `lock_o` in the next cycle and loads count N. `lock_o` rises in the cycle after the (N+1)-th tick that follows the write. A tick in the same cycle as the write is ignored.
- R5: A settling count of 0 raises `lock_o` in the cycle after the first tick that follows the write.
- R6: While the PLL is disabled, `lock_o` stays 0 whatever ticks arrive. A ratio write that disables the PLL clears `lock_o` in the next cycle.
- R7: A ratio write that repeats the current divider, multiplier and count while locked still clears `lock_o` and restarts the full count.
- R8: A write with `wr_addr` = 1 loads the control word. Bit 0 drives `half_o` and bit 1 is the interrupt enable. This write changes neither `lock_o`, the progress of the count, `div_o` nor `mul_o`.
- R9: `irq_o` equals `lock_o` AND the stored interrupt enable, in the same cycle.
- R10: Once set, `lock_o` stays 1 through further ticks until a ratio write or a disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the ratio word, 1 selects the control word |
| wr_data | input | 32 | Write data |
| slow_tick | input | 1 | One-cycle slow-clock tick enable |
| div_o | output | 8 | Stored reference divider |
| mul_o | output | 8 | Stored multiplier (factor is value + 1) |
| half_o | output | 1 | Output halving select |
| pll_en_o | output | 1 | PLL enable (0 means powered down) |
| lock_o | output | 1 | Lock status |
| irq_o | output | 1 | Level lock interrupt request |

## Verification
If the counter is corrupted or loaded from the wrong field, lock rises one or more ticks early or late. The bench sees this in the cycle just after the deciding tick, because it checks lock both before and after the last expected tick. A stale enable or a missed restart leaves lock high after a ratio write or after a disable, and that shows in the very next cycle. A control write that leaks into the timer shows as lock dropping, or as a count that runs longer than expected.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic {
    ADDR_RATIO = 1'b0,
    ADDR_CTRL  = 1'b1
  } reg_addr_e;

  localparam int CTRL_HALF_BIT  = 0;
  localparam int CTRL_IRQEN_BIT = 1;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [MUL_W-1:0]  mul_q,
  output logic              half_q,
  output logic              irq_en_q,
  output logic              en_q,
  output logic              ratio_wr,
  output logic              new_en,
  output logic [CNT_W-1:0]  new_cnt
);
  localparam int MUL_LSB = DIV_W;
  localparam int CNT_LSB = DIV_W + MUL_W;

  logic [DIV_W-1:0] new_div;
  logic [MUL_W-1:0] new_mul;
  logic             ctrl_wr;

  always_comb begin
    ratio_wr = wr_en && (wr_addr == ADDR_RATIO);
    ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    new_div  = wr_data[DIV_W-1:0];
    new_mul  = wr_data[MUL_LSB +: MUL_W];
    new_cnt  = wr_data[CNT_LSB +: CNT_W];
    new_en   = (new_div != '0) && (new_mul != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      mul_q    <= '0;
      en_q     <= 1'b0;
      half_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (ratio_wr) begin
        div_q <= new_div;
        mul_q <= new_mul;
        en_q  <= new_en;
      end
      if (ctrl_wr) begin
        half_q   <= wr_data[CTRL_HALF_BIT];
        irq_en_q <= wr_data[CTRL_IRQEN_BIT];
      end
    end
  end

  // R3
  en_fields_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (div_q != '0) && (mul_q != '0));
  // R8
  ctrl_keeps_ratio_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> $stable(div_q) && $stable(mul_q) && $stable(en_q));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             ratio_wr,
  input  logic             new_en,
  input  logic [CNT_W-1:0] new_cnt,
  input  logic             tick,
  output logic             lock_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (ratio_wr) begin
      lock_q  <= 1'b0;
      armed_q <= new_en;
      cnt_q   <= new_en ? new_cnt : '0;
    end else if (!en_q) begin
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (tick && armed_q) begin
      if (cnt_q == '0) begin
        lock_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    ratio_wr && new_en |=> !lock_q && armed_q && (cnt_q == $past(new_cnt)));
  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    en_q && !ratio_wr && tick && armed_q && (cnt_q != '0)
      |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  // R6
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ratio_wr && !new_en |=> !lock_q && !armed_q);
  // R10
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(tick) && $past(armed_q));
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slow_tick,
  output logic [DIV_W-1:0]  div_o,
  output logic [MUL_W-1:0]  mul_o,
  output logic              half_o,
  output logic              pll_en_o,
  output logic              lock_o,
  output logic              irq_o
);
  logic             irq_en;
  logic             ratio_wr;
  logic             new_en;
  logic [CNT_W-1:0] new_cnt;

  pll_cfg_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .MUL_W(MUL_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .div_q(div_o), .mul_q(mul_o), .half_q(half_o), .irq_en_q(irq_en),
    .en_q(pll_en_o), .ratio_wr(ratio_wr), .new_en(new_en), .new_cnt(new_cnt)
  );

  pll_lock_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .en_q(pll_en_o), .ratio_wr(ratio_wr),
    .new_en(new_en), .new_cnt(new_cnt), .tick(slow_tick), .lock_q(lock_o)
  );

  assign irq_o = lock_o & irq_en;

  // R6
  lock_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> pll_en_o);
  // R9
  irq_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> lock_o);
endmodule

// File: tb/pll_lock_ctrl_tb.sv
module pll_lock_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        slow_tick = 1'b0;
  logic [7:0]  div_o, mul_o;
  logic        half_o, pll_en_o, lock_o, irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_lock_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slow_tick(slow_tick), .div_o(div_o), .mul_o(mul_o), .half_o(half_o),
    .pll_en_o(pll_en_o), .lock_o(lock_o), .irq_o(irq_o)
  );

  // vector: [24] irq enable, [21:16] count, [15:8] multiplier, [7:0] divider
  localparam logic [31:0] VEC [6] = '{
    {7'd0, 1'b1, 2'd0, 6'd3,  8'd1,   8'd1},
    {7'd0, 1'b0, 2'd0, 6'd0,  8'd255, 8'd255},
    {7'd0, 1'b1, 2'd0, 6'd2,  8'd5,   8'd0},
    {7'd0, 1'b1, 2'd0, 6'd4,  8'd0,   8'd7},
    {7'd0, 1'b1, 2'd0, 6'd63, 8'd20,  8'd10},
    {7'd0, 1'b0, 2'd0, 6'd1,  8'd2,   8'd3}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ratio(input logic [7:0] d, input logic [7:0] m,
                                        input logic [5:0] c);
    return {10'd0, c, m, d};
  endfunction

  task automatic wr(input logic a, input logic [31:0] d, input logic tk = 1'b0);
    wr_en = 1'b1; wr_addr = a; wr_data = d; slow_tick = tk;
    @(negedge clk);
    wr_en = 1'b0; slow_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "div",  div_o, 0);
    check("R1", "mul",  mul_o, 0);
    check("R1", "en",   pll_en_o, 0);
    check("R1", "lock", lock_o, 0);
    check("R1", "irq",  irq_o, 0);
    check("R1", "half", half_o, 0);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d, m; logic [5:0] c; logic ie, en;
      d = VEC[v][7:0]; m = VEC[v][15:8]; c = VEC[v][21:16]; ie = VEC[v][24];
      en = (d != 0) && (m != 0);
      wr(1'b1, {30'd0, ie, 1'b0});
      wr(1'b0, ratio(d, m, c));
      check("R2", "div", div_o, d);
      check("R2", "mul", mul_o, m);
      check("R3", "en", pll_en_o, en);
      check("R4", "lock after write", lock_o, 0);
      ticks(c);
      check(en ? "R4" : "R6", "lock before last tick", lock_o, 0);
      ticks(1);
      check(en ? (c == 0 ? "R5" : "R4") : "R6", "lock after last tick", lock_o, en);
      check("R9", "irq", irq_o, en & ie);
      if (en) begin
        ticks(3);
        check("R10", "lock held", lock_o, 1);
      end
    end

    // R7 identical rewrite while locked restarts
    wr(1'b1, 32'h2);
    wr(1'b0, ratio(4, 4, 2));
    ticks(3);
    check("R7", "locked first", lock_o, 1);
    wr(1'b0, ratio(4, 4, 2));
    check("R7", "lock cleared", lock_o, 0);
    ticks(2);
    check("R7", "still counting", lock_o, 0);
    ticks(1);
    check("R7", "relocked", lock_o, 1);

    // R6 disable write clears lock
    wr(1'b0, ratio(4, 0, 2));
    check("R6", "lock cleared by disable", lock_o, 0);
    check("R6", "en off", pll_en_o, 0);
    ticks(5);
    check("R6", "no lock while off", lock_o, 0);

    // R4 tick in the write cycle is ignored
    wr(1'b0, ratio(9, 9, 1), 1'b1);
    ticks(1);
    check("R4", "write-cycle tick ignored", lock_o, 0);
    ticks(1);
    check("R4", "lock after two ticks", lock_o, 1);

    // R8 control write mid-count leaves timer alone; half select
    wr(1'b0, ratio(6, 2, 3));
    ticks(2);
    wr(1'b1, 32'h1);
    check("R8", "half set", half_o, 1);
    check("R8", "div kept", div_o, 6);
    check("R8", "mul kept", mul_o, 2);
    check("R8", "lock still low", lock_o, 0);
    ticks(1);
    check("R8", "count not restarted", lock_o, 0);
    ticks(1);
    check("R8", "lock on schedule", lock_o, 1);
    check("R9", "irq disabled", irq_o, 0);
    wr(1'b1, 32'h2);
    check("R9", "irq enabled", irq_o, 1);
    check("R8", "half cleared", half_o, 0);
    check("R8", "lock kept by ctrl write", lock_o, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule